// File: doc/BRIEF.md
# Bipolar Converter Code Translator

This block converts a signed converter sample from one bipolar number format to another. It accepts four formats: offset binary, twos complement, ones complement and sign-magnitude. A source selector and a destination selector pick the pair, and any pair is allowed, including a format to itself. An optional output stage inverts every bit of the result, which gives the complementary form that some converters need on their data pins.

Each input word is first turned into a twos-complement value, and that value is then encoded into the destination format. The two negative-zero forms collapse to a single zero. The twos-complement most-negative value is the negative full-scale code of offset binary and has no symmetric partner. That value raises an out-of-range flag. It can be clamped one step up, and it saturates whenever the destination cannot represent it. Results are registered. A valid strobe marks each word and reaches the output one clock after the input.

Top module: `bcx_translate`

## Requirements
- R1: Format select encoding is 0 = offset binary, 1 = twos complement, 2 = ones complement, 3 = sign-magnitude. For any value that the destination can represent, the output code represents the same numeric value as the input code.
- R2: Offset-binary zero is 10..0, and an offset-binary code equals the twos-complement code of the same value with only the MSB inverted, in both directions.
- R3: The negative zeros, ones complement 11..1 and sign-magnitude 10..0, translate to the destination's zero code (00..0 for twos complement, ones complement and sign-magnitude; 10..0 for offset binary).
- R4: A most-negative input sets out_range_err for that word. This is offset binary 00..0 or twos complement 10..0.
- R5: With clamp_en high, a most-negative input is treated as one LSB above it. Offset binary then emits 00..01 and twos complement emits 10..01. The flag stays set.
- R6: When the destination is ones complement or sign-magnitude, a most-negative input saturates to the most negative representable code, whatever clamp_en is: 10..0 for ones complement and 11..1 for sign-magnitude. The flag is set.
- R7: With comp_en high, every bit of the translated code is inverted. For offset binary to offset binary, zero gives 01..1.
- R8: out_valid equals in_valid delayed by one clock. out_code and out_range_err show the result of a word one clock after it is presented with in_valid high.
- R9: While in_valid is low, out_code and out_range_err hold their previous values.
- R10: After synchronous reset, out_valid, out_code and out_range_err are all 0.
- R11: Ones-complement and sign-magnitude sources never set out_range_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_code | input | N | Input code |
| src_fmt | input | 2 | Source format select |
| dst_fmt | input | 2 | Destination format select |
| clamp_en | input | 1 | Clamp the most-negative value up by one LSB |
| comp_en | input | 1 | Emit the bit-inverted output code |
| out_valid | output | 1 | Output word strobe |
| out_code | output | N | Translated code |
| out_range_err | output | 1 | Out-of-range flag for the word on out_code |

## Verification
The hardest case to reach is the most-negative value. Only two of the 4·2^N source codes produce it, and it splits three ways on the destination format and clamp_en. Uniform random codes hit it rarely, so the stimulus runs both of those codes directly against all four destinations with clamp on and off. The random phase also forces the MSB-only patterns 10..0, 11..1 and 00..0 often, so that the negative zeros and the saturation path come up among the random cases too.

// File: rtl/bcx_pkg.sv
package bcx_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET  = 2'd0,
    FMT_TWOS    = 2'd1,
    FMT_ONES    = 2'd2,
    FMT_SIGNMAG = 2'd3
  } fmt_e;
endpackage

// File: rtl/bcx_decode.sv
// Any bipolar format -> twos-complement intermediate.
module bcx_decode
  import bcx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] code,
  input  fmt_e         fmt,
  output logic [W-1:0] twos
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] mag;

  assign mag = {1'b0, code[W-2:0]};

  always_comb begin
    unique case (fmt)
      FMT_OFFSET:  twos = {~code[W-1], code[W-2:0]};
      FMT_TWOS:    twos = code;
      FMT_ONES:    twos = code[W-1] ? code + ONE : code;     // 11..1 wraps to 0
      FMT_SIGNMAG: twos = code[W-1] ? (~mag) + ONE : code;   // 10..0 gives 0
      default:     twos = code;
    endcase
  end
endmodule

// File: rtl/bcx_guard.sv
// Detects the most-negative value and applies clamp / saturation.
module bcx_guard
  import bcx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] twos_in,
  input  logic         clamp_en,
  input  fmt_e         dst,
  output logic [W-1:0] twos_out,
  output logic         range_err
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = W'(1);
  logic no_repr;

  assign range_err = (twos_in == MINV);
  assign no_repr   = (dst == FMT_ONES) || (dst == FMT_SIGNMAG);
  assign twos_out  = (range_err && (clamp_en || no_repr)) ? twos_in + ONE : twos_in;
endmodule

// File: rtl/bcx_encode.sv
// Twos-complement intermediate -> destination format, optional complement.
module bcx_encode
  import bcx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] twos,
  input  fmt_e         fmt,
  input  logic         comp_en,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] negv;
  logic [W-1:0] raw;

  assign negv = (~twos) + ONE;

  always_comb begin
    unique case (fmt)
      FMT_OFFSET:  raw = {~twos[W-1], twos[W-2:0]};
      FMT_TWOS:    raw = twos;
      FMT_ONES:    raw = twos[W-1] ? twos - ONE : twos;
      FMT_SIGNMAG: raw = twos[W-1] ? {1'b1, negv[W-2:0]} : twos;
      default:     raw = twos;
    endcase
  end

  assign code = comp_en ? ~raw : raw;
endmodule

// File: rtl/bcx_translate.sv
module bcx_translate
  import bcx_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] in_code,
  input  logic [1:0]   src_fmt,
  input  logic [1:0]   dst_fmt,
  input  logic         clamp_en,
  input  logic         comp_en,
  output logic         out_valid,
  output logic [N-1:0] out_code,
  output logic         out_range_err
);
  logic [N-1:0] twos_raw;
  logic [N-1:0] twos_adj;
  logic [N-1:0] code_nxt;
  logic         err_nxt;

  bcx_decode #(.W(N)) u_dec (
    .code (in_code),
    .fmt  (fmt_e'(src_fmt)),
    .twos (twos_raw)
  );

  bcx_guard #(.W(N)) u_grd (
    .twos_in   (twos_raw),
    .clamp_en  (clamp_en),
    .dst       (fmt_e'(dst_fmt)),
    .twos_out  (twos_adj),
    .range_err (err_nxt)
  );

  bcx_encode #(.W(N)) u_enc (
    .twos    (twos_adj),
    .fmt     (fmt_e'(dst_fmt)),
    .comp_en (comp_en),
    .code    (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_code      <= '0;
      out_range_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code      <= code_nxt;
        out_range_err <= err_nxt;
      end
    end
  end
endmodule

// File: rtl/bcx_translate_chk.sv
module bcx_translate_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [N-1:0] in_code,
  input logic [1:0]   src_fmt,
  input logic [1:0]   dst_fmt,
  input logic         clamp_en,
  input logic         comp_en,
  input logic         out_valid,
  input logic [N-1:0] out_code,
  input logic         out_range_err
);
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_code) && $stable(out_range_err)));
  a_r4_ob_min_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_fmt == 2'd0 && in_code == '0) |=> out_range_err);
  a_r11_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_fmt[1]) |=> !out_range_err);
  a_r3_sm_single_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_fmt == 2'd3 && !comp_en) |=> (out_code != MSB_ONLY));
  a_r3_oc_single_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_fmt == 2'd2 && !comp_en) |=> (out_code != {N{1'b1}}));
  a_r1_identity: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_fmt == 2'd1 && dst_fmt == 2'd1 && !comp_en && !clamp_en)
      |=> (out_code == $past(in_code)));
endmodule

bind bcx_translate bcx_translate_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
  .src_fmt(src_fmt), .dst_fmt(dst_fmt), .clamp_en(clamp_en), .comp_en(comp_en),
  .out_valid(out_valid), .out_code(out_code), .out_range_err(out_range_err)
);

// File: tb/tb_bcx_translate.sv
`timescale 1ns/1ps
module tb_bcx_translate;
  localparam int N    = 8;
  localparam int HALF = 1 << (N-1);
  localparam int FULL = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_code = '0;
  logic [1:0]   src_fmt = '0;
  logic [1:0]   dst_fmt = '0;
  logic         clamp_en = 1'b0;
  logic         comp_en = 1'b0;
  logic         out_valid;
  logic [N-1:0] out_code;
  logic         out_range_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bcx_translate #(.N(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .clamp_en(clamp_en), .comp_en(comp_en),
    .out_valid(out_valid), .out_code(out_code), .out_range_err(out_range_err)
  );

  // Reference: numeric value via integers, then re-encode arithmetically.
  function automatic logic [N:0] ref_out(input logic [N-1:0] c, input logic [1:0] s,
                                         input logic [1:0] d, input logic cl, input logic cp);
    int v, r;
    logic err;
    logic [N-1:0] o;
    case (s)
      2'd0: v = int'(c) - HALF;
      2'd1: v = c[N-1] ? int'(c) - FULL : int'(c);
      2'd2: v = c[N-1] ? int'(c) - (FULL - 1) : int'(c);
      default: v = c[N-1] ? -(int'(c) - HALF) : int'(c);
    endcase
    err = (v == -HALF);
    if (err && (cl || d[1])) v = v + 1;
    case (d)
      2'd0: r = v + HALF;
      2'd1: r = (v < 0) ? v + FULL : v;
      2'd2: r = (v < 0) ? v + FULL - 1 : v;
      default: r = (v < 0) ? HALF - v : v;
    endcase
    o = r[N-1:0];
    if (cp) o = ~o;
    return {err, o};
  endfunction

  task automatic chk(input string tag, input logic [N:0] act, input logic [N:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [N-1:0] c, input logic [1:0] s,
                      input logic [1:0] d, input logic cl, input logic cp,
                      input logic [N:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; src_fmt = s; dst_fmt = d; clamp_en = cl; comp_en = cp;
    @(negedge clk);
    chk({tag, " valid"}, {{N{1'b0}}, out_valid}, {{N{1'b0}}, 1'b1});
    chk(tag, {out_range_err, out_code}, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [N:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {out_range_err, out_code}, '0);
    chk("R10 reset valid", {{N{1'b0}}, out_valid}, '0);
    rst = 1'b0;

    // R2 / R1 directed
    send("R2 ob zero to tc", 8'h80, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 8'h00});
    send("R2 tc to ob", 8'h05, 2'd1, 2'd0, 1'b0, 1'b0, {1'b0, 8'h85});
    send("R1 tc -3 to sm", 8'hFD, 2'd1, 2'd3, 1'b0, 1'b0, {1'b0, 8'h83});
    send("R1 sm -3 to oc", 8'h83, 2'd3, 2'd2, 1'b0, 1'b0, {1'b0, 8'hFC});
    // R3 negative zeros
    send("R3 oc negzero to tc", 8'hFF, 2'd2, 2'd1, 1'b0, 1'b0, {1'b0, 8'h00});
    send("R3 sm negzero to ob", 8'h80, 2'd3, 2'd0, 1'b0, 1'b0, {1'b0, 8'h80});
    send("R3 oc negzero to sm", 8'hFF, 2'd2, 2'd3, 1'b0, 1'b0, {1'b0, 8'h00});
    // R4 / R5 / R6 most-negative value
    send("R4 ob min to tc", 8'h00, 2'd0, 2'd1, 1'b0, 1'b0, {1'b1, 8'h80});
    send("R4 tc min to ob", 8'h80, 2'd1, 2'd0, 1'b0, 1'b0, {1'b1, 8'h00});
    send("R5 ob min clamp", 8'h00, 2'd0, 2'd0, 1'b1, 1'b0, {1'b1, 8'h01});
    send("R5 tc min clamp", 8'h80, 2'd1, 2'd1, 1'b1, 1'b0, {1'b1, 8'h81});
    send("R6 tc min to sm", 8'h80, 2'd1, 2'd3, 1'b0, 1'b0, {1'b1, 8'hFF});
    send("R6 ob min to oc", 8'h00, 2'd0, 2'd2, 1'b1, 1'b0, {1'b1, 8'h80});
    // R7 complement
    send("R7 ob zero comp", 8'h80, 2'd0, 2'd0, 1'b0, 1'b1, {1'b0, 8'h7F});
    // R11
    send("R11 sm max neg", 8'hFF, 2'd3, 2'd1, 1'b0, 1'b0, {1'b0, 8'h81});

    // R9 hold: new inputs with in_valid low must not change outputs
    held = {out_range_err, out_code};
    @(negedge clk);
    in_valid = 1'b0; in_code = 8'h00; src_fmt = 2'd0; dst_fmt = 2'd1;
    @(negedge clk);
    chk("R8 valid low", {{N{1'b0}}, out_valid}, '0);
    chk("R9 hold", {out_range_err, out_code}, held);

    // Exhaustive corner sweep for the minimum over all destinations
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 4; d++)
        for (int k = 0; k < 2; k++) begin
          logic [N-1:0] c;
          c = (s == 0) ? 8'h00 : 8'h80;
          send("R4 R5 R6 sweep", c, 2'(s), 2'(d), k[0], 1'b0,
               ref_out(c, 2'(s), 2'(d), k[0], 1'b0));
        end

    // R1 R7 random
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] c;
      logic [1:0] s, d;
      logic cl, cp;
      case ($urandom % 5)
        0: c = 8'h80;
        1: c = 8'hFF;
        2: c = 8'h00;
        default: c = N'($urandom);
      endcase
      s = 2'($urandom); d = 2'($urandom);
      cl = 1'($urandom); cp = 1'($urandom);
      send("R1 R7 random", c, s, d, cl, cp, ref_out(c, s, d, cl, cp));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule